// File: doc/BRIEF.md
# Filtered Edge-Capture Channel

This block is one capture channel of a timer. It watches an asynchronous input pin, cleans it up with a synchronizer and a coded digital noise filter, and picks out either rising or falling edges of the cleaned level. It can skip edges by a power-of-two ratio. On every edge that survives, it copies the value of an external free-running counter into a capture register. It also raises a one-cycle request pulse that an interrupt controller or a transfer engine can use.

A host programs the channel through a small register port. The control register holds enable, polarity, prescale ratio and filter code. The status register holds a capture flag and a sticky overcapture flag, and both clear when a one is written to them. The capture register returns the latched count, and reading it also clears the capture flag.

The filter always restarts its sampling divider when the input first differs from the accepted level. The time from a pin change to the capture is therefore a fixed number of cycles for each filter code, with no jitter. With the default two synchronizer stages, a pin change made during the cycle before clock edge k is captured at edge k+3+(N-1)·D, where N is the sample count and D the sampling divisor. The capture register then holds the counter value that was present just before that edge. The filter codes are:

| Code | D | N |
|---|---|---|
| 0 | 1 | 1 |
| 1 | 1 | 2 |
| 2 | 1 | 4 |
| 3 | 2 | 8 |
| 4, 5 | 2·S | 6, 8 |
| 6, 7 | 4·S | 6, 8 |
| 8, 9 | 8·S | 6, 8 |
| 10, 11, 12 | 16·S | 5, 6, 8 |
| 13, 14, 15 | 32·S | 5, 6, 8 |

Here S is the parameter `DTS_DIV`, the ratio of the sampling-base clock to the timer clock, which defaults to 1. `CNT_W` must be greater than 8.

The filter is a state machine with four states:
- FLT_LOW: the accepted level is low.
- FLT_RISE: a high level is pending.
- FLT_HIGH: the accepted level is high.
- FLT_FALL: a low level is pending.

Its transitions are:
- LOW→RISE, or LOW→HIGH when N=1, on a high input.
- RISE→HIGH on the N-th consecutive high sample.
- RISE→LOW on any low sample.
- HIGH→FALL, or HIGH→LOW when N=1, on a low input.
- FALL→LOW on the N-th consecutive low sample.
- FALL→HIGH on any high sample.

The edge stage is a state machine with two states, CH_IDLE (disabled, edge counter held at zero) and CH_COUNT (counting qualified edges). It moves from IDLE to COUNT when enable is 1, and from COUNT to IDLE when enable is 0.

Top module: `edge_capture_channel`

## Requirements
- R1: After reset, every register reads zero: control (address 0), status (address 1) and capture (address 2). The request output is low.
- R2: With control bit 1 at 0, captures happen on rising edges of the filtered input only, and falling edges cause no request.
- R3: With control bit 1 at 1, captures happen on falling edges of the filtered input only, and rising edges cause no request.
- R4: With filter code 0 (control bits 7:4), a pin change is captured 3 cycles after the first clock edge that follows it. The capture register holds the counter value seen at that edge.
- R5: Filter code 1 needs 2 consecutive equal samples at the timer clock, which gives a capture offset of 4 cycles.
- R6: Filter code 3 samples every 2 cycles and needs 8 equal samples, which gives a capture offset of 17 cycles. A 6-cycle pulse is rejected.
- R7: Filter code 15 samples every 32·S cycles and needs 8 equal samples, which gives a capture offset of 227 cycles at S=1.
- R8: Control bits 3:2 select the ratio 1, 2, 4 or 8 (codes 0 to 3). Only every ratio-th qualified edge is captured, and the first capture after enabling falls on the ratio-th edge.
- R9: Clearing and then setting the enable bit (control bit 0) restarts the edge count, so edges seen before the disable do not count.
- R10: Status bit 0 sets on a capture. It clears when the capture register is read or when a 1 is written to it, and a capture in the same cycle wins over the clear.
- R11: Status bit 1 sets when a capture occurs while status bit 0 is already set. It stays set until a 1 is written to it.
- R12: Each capture gives exactly one one-cycle pulse on cap_req, in the cycle the capture register takes its new value.
- R13: While control bit 0 is 0, no capture occurs and the capture register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_in | input | 1 | Asynchronous signal to be measured |
| counter | input | CNT_W | Free-running timer count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the read-side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 capture |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| cap_req | output | 1 | One-cycle capture request pulse |

## Verification
The main function is driven with isolated single edges under filter codes 0, 1, 3 and 15. These tell apart a correct sample count and sampling divisor from an off-by-one in either, because the request must be low in the cycle before the expected edge and high in that exact cycle. Edges of the wrong polarity, and a pulse shorter than the filter window, separate true qualified edges from raw or unfiltered transitions. Trains of 4 and 8 edges under each prescale ratio, one train broken by a disable and re-enable, separate a proper edge count from one that is off, free-running or never restarted. Back-to-back captures with no clear in between, followed by single-bit clears, separate the sticky overcapture flag from the capture flag.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CAP  = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_FALL_BIT = 1;
    localparam int CTRL_PSC_LSB  = 2;
    localparam int CTRL_FLT_LSB  = 4;
    localparam int STAT_CAP_BIT  = 0;
    localparam int STAT_OVR_BIT  = 1;

    typedef enum logic [1:0] {
        FLT_LOW  = 2'd0,
        FLT_RISE = 2'd1,
        FLT_HIGH = 2'd2,
        FLT_FALL = 2'd3
    } flt_state_e;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    // Sampling divisor (in timer-clock cycles) chosen by the filter code.
    function automatic int unsigned flt_divisor(input logic [3:0] code,
                                                input int unsigned smp_base);
        int unsigned d;
        unique case (code)
            4'd0, 4'd1, 4'd2:   d = 1;
            4'd3:               d = 2;
            4'd4, 4'd5:         d = 2 * smp_base;
            4'd6, 4'd7:         d = 4 * smp_base;
            4'd8, 4'd9:         d = 8 * smp_base;
            4'd10, 4'd11, 4'd12: d = 16 * smp_base;
            default:            d = 32 * smp_base;
        endcase
        return d;
    endfunction

    // Number of consecutive equal samples needed to accept a level.
    function automatic logic [3:0] flt_length(input logic [3:0] code);
        logic [3:0] n;
        unique case (code)
            4'd0:                      n = 4'd1;
            4'd1:                      n = 4'd2;
            4'd2:                      n = 4'd4;
            4'd4, 4'd6, 4'd8, 4'd11, 4'd14: n = 4'd6;
            4'd10, 4'd13:              n = 4'd5;
            default:                   n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ecap_filter.sv
module ecap_filter
    import ecap_pkg::*;
#(
    parameter int DTS_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [3:0] code,
    output logic       lvl
);
    localparam int MAX_DIV = 32 * DTS_DIV;
    localparam int DIV_W   = $clog2(MAX_DIV) + 1;

    flt_state_e       st, st_nxt;
    logic [DIV_W-1:0] div_need, div_cnt;
    logic [3:0]       len_need, run_cnt;
    logic             tick, done;

    always_comb begin
        div_need = DIV_W'(flt_divisor(code, DTS_DIV));
        len_need = flt_length(code);
        tick     = (div_cnt >= div_need - DIV_W'(1));
        done     = ((run_cnt + 4'd1) >= len_need);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= FLT_LOW;
        else        st <= st_nxt;
    end

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            FLT_LOW: begin
                if (din) st_nxt = (len_need == 4'd1) ? FLT_HIGH : FLT_RISE;
            end
            FLT_RISE: begin
                if (tick) begin
                    if (!din)      st_nxt = FLT_LOW;
                    else if (done) st_nxt = FLT_HIGH;
                end
            end
            FLT_HIGH: begin
                if (!din) st_nxt = (len_need == 4'd1) ? FLT_LOW : FLT_FALL;
            end
            FLT_FALL: begin
                if (tick) begin
                    if (din)       st_nxt = FLT_HIGH;
                    else if (done) st_nxt = FLT_LOW;
                end
            end
            default: st_nxt = FLT_LOW;
        endcase
    end

    // Sampling divider and run counter restart whenever a level is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            run_cnt <= 4'd1;
        end else if (st == FLT_LOW || st == FLT_HIGH) begin
            div_cnt <= '0;
            run_cnt <= 4'd1;
        end else if (tick) begin
            div_cnt <= '0;
            run_cnt <= run_cnt + 4'd1;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // Output decode
    always_comb begin
        unique case (st)
            FLT_HIGH, FLT_FALL: lvl = 1'b1;
            default:            lvl = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecap_edge_presc.sv
module ecap_edge_presc
    import ecap_pkg::*;
#(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             en,
    input  logic             fall_sel,
    input  logic [PSC_W-1:0] psc,
    output logic             fire
);
    localparam int MAX_RATIO = 1 << ((1 << PSC_W) - 1);
    localparam int ECNT_W    = $clog2(MAX_RATIO) + 1;

    ch_state_e         st, st_nxt;
    logic              lvl_q, qual, hit;
    logic [ECNT_W-1:0] ecnt, ratio_m1;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    always_comb begin
        qual     = fall_sel ? (lvl_q & ~lvl) : (lvl & ~lvl_q);
        ratio_m1 = ECNT_W'((1 << psc) - 1);
        hit      = (ecnt >= ratio_m1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nxt;
    end

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_IDLE:  if (en)  st_nxt = CH_COUNT;
            CH_COUNT: if (!en) st_nxt = CH_IDLE;
            default:  st_nxt = CH_IDLE;
        endcase
    end

    // Edge counter: held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= '0;
        end else if (st == CH_IDLE) begin
            ecnt <= '0;
        end else if (qual && en) begin
            ecnt <= hit ? '0 : ecnt + ECNT_W'(1);
        end
    end

    // Output decode
    always_comb begin
        unique case (st)
            CH_COUNT: fire = en & qual & hit;
            default:  fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/edge_capture_channel.sv
module edge_capture_channel
    import ecap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DTS_DIV     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] counter,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             cap_req
);
    localparam int PSC_W = 2;
    localparam int FLT_W = 4;

    logic             sync_lvl, filt_lvl, fire;
    logic             ctrl_en, ctrl_fall;
    logic [PSC_W-1:0] ctrl_psc;
    logic [FLT_W-1:0] ctrl_code;
    logic             cap_flag, ovr_flag;
    logic [CNT_W-1:0] cap_val;
    logic             wr_ctrl, wr_stat, rd_cap;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[CNT_W-1:8];

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
    );

    ecap_filter #(.DTS_DIV(DTS_DIV)) u_filter (
        .clk(clk), .rst_n(rst_n), .din(sync_lvl), .code(ctrl_code), .lvl(filt_lvl)
    );

    ecap_edge_presc #(.PSC_W(PSC_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .en(ctrl_en),
        .fall_sel(ctrl_fall), .psc(ctrl_psc), .fire(fire)
    );

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        rd_cap  = reg_rd && (reg_addr == ADDR_CAP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_fall <= 1'b0;
            ctrl_psc  <= '0;
            ctrl_code <= '0;
        end else if (wr_ctrl) begin
            ctrl_en   <= reg_wdata[CTRL_EN_BIT];
            ctrl_fall <= reg_wdata[CTRL_FALL_BIT];
            ctrl_psc  <= reg_wdata[CTRL_PSC_LSB +: PSC_W];
            ctrl_code <= reg_wdata[CTRL_FLT_LSB +: FLT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (fire)
                cap_flag <= 1'b1;
            else if (rd_cap || (wr_stat && reg_wdata[STAT_CAP_BIT]))
                cap_flag <= 1'b0;

            if (fire && cap_flag)
                ovr_flag <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_OVR_BIT])
                ovr_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val <= '0;
            cap_req <= 1'b0;
        end else begin
            cap_req <= fire;
            if (fire) cap_val <= counter;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = CNT_W'({ctrl_code, ctrl_psc, ctrl_fall, ctrl_en});
            ADDR_STAT: reg_rdata = CNT_W'({ovr_flag, cap_flag});
            ADDR_CAP:  reg_rdata = cap_val;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecap_checks.sv
module ecap_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_req,
    input logic [CNT_W-1:0] counter,
    input logic [CNT_W-1:0] cap_val,
    input logic             ctrl_en,
    input logic             cap_flag,
    input logic             ovr_flag,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wdata_b1,
    input logic             filt_lvl,
    input logic             sync_lvl
);
    p_capture_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |-> cap_val == $past(counter));

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |=> !cap_req);

    p_flag_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |-> cap_flag);

    p_quiet_when_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !cap_req);

    p_value_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_req |-> $stable(cap_val));

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(reg_wr && reg_addr == 2'd1 && wdata_b1)) |=> ovr_flag);

    p_filter_agrees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_lvl) |-> filt_lvl == $past(sync_lvl));
endmodule

bind edge_capture_channel ecap_checks #(.CNT_W(CNT_W)) u_ecap_checks (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .counter(counter),
    .cap_val(cap_val), .ctrl_en(ctrl_en), .cap_flag(cap_flag),
    .ovr_flag(ovr_flag), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata_b1(reg_wdata[1]), .filt_lvl(filt_lvl), .sync_lvl(sync_lvl)
);

// File: tb/test_edge_capture_channel.sv
`timescale 1ns/1ps
module test_edge_capture_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] ctr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] rdata;
    logic        cap_req;
    int          n_checks = 0, n_fail = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_CAP = 2'd2;

    edge_capture_channel i_edge_capture_channel (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .counter(ctr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .cap_req(cap_req)
    );

    initial forever #2.5 clk = ~clk;
    initial forever @(posedge clk) ctr <= ctr + 16'd1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [15:0] cw(input bit en, input bit fall,
                                       input logic [1:0] psc, input logic [3:0] code);
        return {8'd0, code, psc, fall, en};
    endfunction

    task automatic set_ctrl(input logic [15:0] w);
        reg_write(A_CTRL, 16'd0);
        reg_write(A_CTRL, w);
    endtask

    // Drive one pin transition and check the request lands exactly at the offset.
    task automatic drive_edge(input logic lvl, input int offset, input bit expect_cap,
                              input string tag, input bit rdcap);
        logic [15:0] c0, v;
        @(negedge clk); pin = lvl; c0 = ctr;
        repeat (offset) @(posedge clk);
        @(negedge clk); check({tag, " req early"}, cap_req, 0);
        @(negedge clk); check({tag, " req"}, cap_req, expect_cap);
        @(negedge clk); check({tag, " req width"}, cap_req, 0);
        if (expect_cap && rdcap) begin
            reg_read(A_CAP, v);
            check({tag, " value"}, v, 16'(c0 + 16'(offset)));
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 req", cap_req, 0);
        reg_read(A_CTRL, v); check("R1 ctrl", v, 0);
        reg_read(A_STAT, v); check("R1 stat", v, 0);
        reg_read(A_CAP, v);  check("R1 cap", v, 0);
    endtask

    task automatic t_rise_code0();
        set_ctrl(cw(1, 0, 2'd0, 4'd0));
        drive_edge(1'b1, 3, 1, "R4 R2 R12 rise", 1);
        drive_edge(1'b0, 3, 0, "R2 fall ignored", 0);
    endtask

    task automatic t_code1();
        set_ctrl(cw(1, 0, 2'd0, 4'd1));
        drive_edge(1'b1, 4, 1, "R5", 1);
        drive_edge(1'b0, 4, 0, "R5 fall", 0);
    endtask

    task automatic t_code3();
        logic [15:0] v;
        set_ctrl(cw(1, 0, 2'd0, 4'd3));
        @(negedge clk); pin = 1'b1;
        repeat (6) @(negedge clk);
        pin = 1'b0;
        repeat (40) @(negedge clk);
        reg_read(A_STAT, v); check("R6 glitch rejected", v, 0);
        drive_edge(1'b1, 17, 1, "R6", 1);
        drive_edge(1'b0, 17, 0, "R6 fall", 0);
    endtask

    task automatic t_code15();
        set_ctrl(cw(1, 0, 2'd0, 4'd15));
        drive_edge(1'b1, 227, 1, "R7", 1);
        drive_edge(1'b0, 227, 0, "R7 fall", 0);
    endtask

    task automatic t_falling();
        set_ctrl(cw(1, 1, 2'd0, 4'd0));
        drive_edge(1'b1, 3, 0, "R3 rise ignored", 0);
        drive_edge(1'b0, 3, 1, "R3 fall", 1);
    endtask

    task automatic t_presc();
        set_ctrl(cw(1, 0, 2'd1, 4'd0));
        for (int i = 0; i < 4; i++) begin
            drive_edge(1'b1, 3, (i % 2) == 1, "R8 div2", 1);
            drive_edge(1'b0, 3, 0, "R8 div2 fall", 0);
        end
        set_ctrl(cw(1, 0, 2'd3, 4'd0));
        for (int i = 0; i < 8; i++) begin
            drive_edge(1'b1, 3, i == 7, "R8 div8", 1);
            drive_edge(1'b0, 3, 0, "R8 div8 fall", 0);
        end
    endtask

    task automatic t_reenable();
        set_ctrl(cw(1, 0, 2'd2, 4'd0));
        for (int i = 0; i < 2; i++) begin
            drive_edge(1'b1, 3, 0, "R9 pre", 0);
            drive_edge(1'b0, 3, 0, "R9 pre fall", 0);
        end
        reg_write(A_CTRL, cw(0, 0, 2'd2, 4'd0));
        reg_write(A_CTRL, cw(1, 0, 2'd2, 4'd0));
        for (int i = 0; i < 4; i++) begin
            drive_edge(1'b1, 3, i == 3, "R9 restart", 1);
            drive_edge(1'b0, 3, 0, "R9 fall", 0);
        end
    endtask

    task automatic t_flags();
        logic [15:0] v;
        set_ctrl(cw(1, 0, 2'd0, 4'd0));
        reg_write(A_STAT, 16'd3);
        drive_edge(1'b1, 3, 1, "R10 first", 0);
        drive_edge(1'b0, 3, 0, "R10 fall", 0);
        reg_read(A_STAT, v); check("R10 flag set", v, 1);
        drive_edge(1'b1, 3, 1, "R11 second", 0);
        drive_edge(1'b0, 3, 0, "R11 fall", 0);
        reg_read(A_STAT, v); check("R11 overcapture", v, 3);
        reg_write(A_STAT, 16'd1);
        reg_read(A_STAT, v); check("R10 w1c flag R11 sticky", v, 2);
        reg_write(A_STAT, 16'd0);
        reg_read(A_STAT, v); check("R11 write zero no effect", v, 2);
        drive_edge(1'b1, 3, 1, "R10 third", 1);
        drive_edge(1'b0, 3, 0, "R10 fall", 0);
        reg_read(A_STAT, v); check("R10 read clears", v, 2);
        reg_write(A_STAT, 16'd2);
        reg_read(A_STAT, v); check("R11 cleared", v, 0);
    endtask

    task automatic t_disabled();
        logic [15:0] v0, v;
        reg_read(A_CAP, v0);
        reg_write(A_CTRL, cw(0, 0, 2'd0, 4'd0));
        drive_edge(1'b1, 3, 0, "R13 rise", 0);
        drive_edge(1'b0, 3, 0, "R13 fall", 0);
        reg_read(A_STAT, v); check("R13 no flag", v, 0);
        reg_read(A_CAP, v);  check("R13 value kept", v, v0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_code0();
        t_code1();
        t_code3();
        t_code15();
        t_falling();
        t_presc();
        t_reenable();
        t_flags();
        t_disabled();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule